// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block multiplies two 32-bit operands and either puts the 64-bit result into a pair of 32-bit accumulator registers or combines it with them. HI holds the upper word and LO the lower word. The operation code selects signed or unsigned arithmetic. It also selects one of three uses of the product: overwrite the pair, add the product to it, or subtract the product from it. Accumulation wraps around at 64 bits and never reports overflow.

A start strobe launches an operation. The latency is fixed at two clock edges. A `busy` flag covers the cycle in between. A one-cycle `done` pulse appears when HI and LO take their new value. Software-style move-to writes load HI and LO on their own, and the move-from view is the continuously driven `hi_o` / `lo_o` outputs. While an operation is in flight, move-to writes and further start strobes are dropped.

Top module: `hilo_mac`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, HI and LO read zero and `busy_o` and `done_o` are low.
- R2: The op codes are as follows: 0 = signed multiply, 1 = unsigned multiply, 2 = signed multiply-add, 3 = unsigned multiply-add, 4 = signed multiply-subtract, 5 = unsigned multiply-subtract. A start with code 6 or 7 is ignored: `busy_o` does not rise, no `done_o` pulse follows, and HI/LO are unchanged.
- R3: A start accepted at a clock edge drives `busy_o` high for exactly the next cycle. At the following edge, HI/LO take the result and `done_o` is high for exactly one cycle.
- R4: Of the 64-bit result, bits 63:32 go to HI and bits 31:0 go to LO.
- R5: Signed operations sign-extend both operands to 64 bits before multiplying. A plain multiply replaces HI/LO and ignores their previous value.
- R6: Unsigned operations zero-extend both operands to 64 bits before multiplying.
- R7: Multiply-add sets {HI,LO} to {HI,LO} plus the product, modulo 2^64, and gives no overflow indication.
- R8: Multiply-subtract sets {HI,LO} to {HI,LO} minus the product, modulo 2^64.
- R9: A start presented while `busy_o` is high is ignored. It causes no second result and no second `done_o` pulse.
- R10: When `busy_o` is low, a move-to write of HI or LO loads that register at the next edge, and HI and LO can be written independently. If a write and an accepted start share an edge, the write lands first, and an accumulate operation then uses the written value.
- R11: A move-to write presented while `busy_o` is high is ignored.
- R12: With no write and no completing operation, HI and LO hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch an operation |
| op_i | input | 3 | Operation code (see R2) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| hi_wr_i | input | 1 | Move-to-HI strobe |
| hi_wdata_i | input | 32 | Move-to-HI data |
| lo_wr_i | input | 1 | Move-to-LO strobe |
| lo_wdata_i | input | 32 | Move-to-LO data |
| hi_o | output | 32 | Current HI value |
| lo_o | output | 32 | Current LO value |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle pulse when HI/LO are updated |

## Verification
The bench targets several corner cases:
- **Carry and borrow across the word boundary.** A design that treated HI and LO as independent 32-bit adders would leave HI wrong here.
- **Wrap-around at 2^64.** A design that saturated, or flagged the wrap, would show a non-zero pair or a stray value.
- **Extension of negative and most-negative operands.** If signed and unsigned extension were swapped, the result would differ in HI only.
- **Strobes arriving during the busy cycle.** A design that accepted them would produce a second `done_o` pulse, or corrupt the pending result.
- **A move-to write on the same edge as an accepted accumulate.** A design with the wrong priority would accumulate into the stale value.

// File: rtl/hilo_mac_pkg.sv
// Shared types for the HI/LO multiply-accumulate unit.
// Assumes a 3-bit op code; codes above the last legal one are reserved.
package hilo_mac_pkg;

    typedef enum logic [2:0] {
        OP_MUL_S  = 3'd0,
        OP_MUL_U  = 3'd1,
        OP_MADD_S = 3'd2,
        OP_MADD_U = 3'd3,
        OP_MSUB_S = 3'd4,
        OP_MSUB_U = 3'd5
    } mac_op_e;

    typedef enum logic [1:0] {
        ACC_LOAD = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_SUB  = 2'd2
    } acc_mode_e;

    // True when the code names one of the six operations.
    function automatic logic op_is_legal(input logic [2:0] op);
        return op <= 3'd5;
    endfunction

    // True when the operands are treated as two's complement.
    function automatic logic op_is_signed(input logic [2:0] op);
        return (op <= 3'd5) && !op[0];
    endfunction

    // How the product is combined with the accumulator.
    function automatic acc_mode_e op_acc_mode(input logic [2:0] op);
        acc_mode_e m;
        case (op)
            3'd2, 3'd3: m = ACC_ADD;
            3'd4, 3'd5: m = ACC_SUB;
            default:    m = ACC_LOAD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hilo_mac_ctrl.sv
// Sequencing for the multiply-accumulate unit.
// Accepts a start only when idle and the op code is legal, keeps busy high
// for one cycle, then pulses done as the accumulator commits.
// Assumes a fixed two-edge latency with no stalls.
module hilo_mac_ctrl
    import hilo_mac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [2:0] op_i,
    output logic       accept_o,
    output logic       busy_o,
    output logic       done_o
);

    logic busy_q;
    logic done_q;

    // A start is taken only between operations and only for a legal code.
    always_comb accept_o = start_i && !busy_q && op_is_legal(op_i);

    // Busy covers the cycle between acceptance and commit; done follows it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            busy_q <= accept_o;
            done_q <= busy_q;
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

endmodule

// File: rtl/hilo_mac_mul.sv
// First stage: extends both operands according to the op's signedness,
// multiplies them to a 2*DW product and registers it with the accumulate mode.
// Assumes load_i is high only for an accepted start.
module hilo_mac_mul
    import hilo_mac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [2:0]      op_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    output logic [2*DW-1:0] prod_o,
    output acc_mode_e       mode_o
);

    localparam int PW = 2 * DW;

    logic [DW-1:0] opnd [2];
    logic [PW-1:0] ext  [2];
    logic          sgn;
    logic [PW-1:0] prod_d;
    logic [PW-1:0] prod_q;
    acc_mode_e     mode_q;

    assign opnd[0] = a_i;
    assign opnd[1] = b_i;

    // Signedness of both operands follows the op code.
    always_comb sgn = op_is_signed(op_i);

    // Widen each operand by sign or zero extension.
    for (genvar g = 0; g < 2; g++) begin : g_ext
        always_comb ext[g] = {{DW{sgn & opnd[g][DW-1]}}, opnd[g]};
    end

    // Low 2*DW bits of the widened product are exact for both signednesses.
    always_comb prod_d = ext[0] * ext[1];

    // Capture the product and the mode when an operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            mode_q <= ACC_LOAD;
        end else if (load_i) begin
            prod_q <= prod_d;
            mode_q <= op_acc_mode(op_i);
        end
    end

    assign prod_o = prod_q;
    assign mode_o = mode_q;

endmodule

// File: rtl/hilo_mac_acc.sv
// HI/LO accumulator pair. On commit it loads, adds or subtracts the product
// modulo 2^(2*DW); otherwise it accepts independent move-to writes.
// Assumes commit_i is high exactly in the cycle an operation is in flight.
module hilo_mac_acc
    import hilo_mac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit_i,
    input  acc_mode_e       mode_i,
    input  logic [2*DW-1:0] prod_i,
    input  logic            hi_wr_i,
    input  logic [DW-1:0]   hi_wdata_i,
    input  logic            lo_wr_i,
    input  logic [DW-1:0]   lo_wdata_i,
    output logic [DW-1:0]   hi_o,
    output logic [DW-1:0]   lo_o
);

    localparam int PW = 2 * DW;

    logic [DW-1:0] hi_q;
    logic [DW-1:0] lo_q;
    logic [PW-1:0] acc;
    logic [PW-1:0] next_acc;

    assign acc = {hi_q, lo_q};

    // Select the committed value; the add and subtract wrap silently.
    always_comb begin
        case (mode_i)
            ACC_ADD: next_acc = acc + prod_i;
            ACC_SUB: next_acc = acc - prod_i;
            default: next_acc = prod_i;
        endcase
    end

    // Commit has priority; move-to writes only land when nothing is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (commit_i) begin
            hi_q <= next_acc[PW-1:DW];
            lo_q <= next_acc[DW-1:0];
        end else begin
            if (hi_wr_i) hi_q <= hi_wdata_i;
            if (lo_wr_i) lo_q <= lo_wdata_i;
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

endmodule

// File: rtl/hilo_mac.sv
// Top of the HI/LO multiply-accumulate unit: control, multiply stage and
// accumulator pair. Results appear two edges after an accepted start.
module hilo_mac
    import hilo_mac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          hi_wr_i,
    input  logic [DW-1:0] hi_wdata_i,
    input  logic          lo_wr_i,
    input  logic [DW-1:0] lo_wdata_i,
    output logic [DW-1:0] hi_o,
    output logic [DW-1:0] lo_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam int PW = 2 * DW;

    logic          accept;
    logic          busy;
    logic [PW-1:0] prod;
    acc_mode_e     mode;

    hilo_mac_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .op_i     (op_i),
        .accept_o (accept),
        .busy_o   (busy),
        .done_o   (done_o)
    );

    hilo_mac_mul #(.DW(DW)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .op_i   (op_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod),
        .mode_o (mode)
    );

    hilo_mac_acc #(.DW(DW)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (busy),
        .mode_i     (mode),
        .prod_i     (prod),
        .hi_wr_i    (hi_wr_i),
        .hi_wdata_i (hi_wdata_i),
        .lo_wr_i    (lo_wr_i),
        .lo_wdata_i (lo_wdata_i),
        .hi_o       (hi_o),
        .lo_o       (lo_o)
    );

    assign busy_o = busy;

endmodule

// File: rtl/hilo_mac_checker.sv
// Protocol checks on the ports of hilo_mac, bound to every instance.
module hilo_mac_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [2:0]    op_i,
    input logic          hi_wr_i,
    input logic          lo_wr_i,
    input logic [DW-1:0] hi_o,
    input logic [DW-1:0] lo_o,
    input logic          busy_o,
    input logic          done_o
);

    assert_busy_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o);

    assert_done_follows_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> done_o);

    assert_done_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    assert_start_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i <= 3'd5) |=> busy_o);

    assert_bad_op_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i > 3'd5) |=> !busy_o);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !busy_o);

    assert_hi_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !hi_wr_i) |=> $stable(hi_o));

    assert_lo_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !lo_wr_i) |=> $stable(lo_o));

endmodule

bind hilo_mac hilo_mac_checker #(.DW(DW)) u_hilo_mac_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .hi_wr_i (hi_wr_i),
    .lo_wr_i (lo_wr_i),
    .hi_o    (hi_o),
    .lo_o    (lo_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/hilo_mac_test.sv
// Self-checking bench: behavioural reference model compared every cycle,
// plus directed checks with hand-computed values.
module hilo_mac_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [31:0] a_i = '0, b_i = '0;
    logic        hi_wr_i = 1'b0, lo_wr_i = 1'b0;
    logic [31:0] hi_wdata_i = '0, lo_wdata_i = '0;
    logic [31:0] hi_o, lo_o;
    logic        busy_o, done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    hilo_mac uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .hi_wr_i(hi_wr_i), .hi_wdata_i(hi_wdata_i),
        .lo_wr_i(lo_wr_i), .lo_wdata_i(lo_wdata_i), .hi_o(hi_o), .lo_o(lo_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    // Reference model state
    logic [63:0] m_acc;
    bit          m_busy, m_done;
    int          p_op;
    logic [31:0] p_a, p_b;

    // Model update on every rising edge from the same inputs the design sees.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0; m_busy = 0; m_done = 0;
        end else begin
            bit acc_ok;
            acc_ok = start_i && !m_busy && (op_i < 3'd6);
            m_done = m_busy;
            if (m_busy) begin
                logic [63:0] p;
                if (p_op % 2 == 0) p = longint'($signed(p_a)) * longint'($signed(p_b));
                else               p = {32'd0, p_a} * {32'd0, p_b};
                case (p_op / 2)
                    0: m_acc = p;
                    1: m_acc = m_acc + p;
                    default: m_acc = m_acc - p;
                endcase
            end else begin
                if (hi_wr_i) m_acc[63:32] = hi_wdata_i;
                if (lo_wr_i) m_acc[31:0]  = lo_wdata_i;
            end
            if (acc_ok) begin p_op = int'(op_i); p_a = a_i; p_b = b_i; end
            m_busy = acc_ok;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R4/R12 model hilo", {hi_o, lo_o}, m_acc);
            chk("R3 model busy", {63'd0, busy_o}, {63'd0, m_busy});
            chk("R3 model done", {63'd0, done_o}, {63'd0, m_done});
        end
    end

    task automatic mt(input bit wh, input logic [31:0] dh, input bit wl, input logic [31:0] dl);
        hi_wr_i = wh; hi_wdata_i = dh; lo_wr_i = wl; lo_wdata_i = dl;
        @(negedge clk);
        hi_wr_i = 0; lo_wr_i = 0;
    endtask

    // Launch one op and check busy and done timing; leaves us in the done cycle.
    task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        start_i = 1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 0;
        chk("R3 busy after start", {63'd0, busy_o, done_o}, 64'd2);
        @(negedge clk);
        chk("R3 done pulse", {63'd0, busy_o, done_o}, 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", {hi_o, lo_o}, 64'd0);
        chk("R1 reset flags", {62'd0, busy_o, done_o}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", {hi_o, lo_o, 62'd0, busy_o, done_o} >> 2, 64'd0);

        mt(1, 32'h1234_5678, 1, 32'h9abc_def0);
        chk("R10 move-to both", {hi_o, lo_o}, 64'h1234_5678_9abc_def0);
        mt(0, 32'h0, 1, 32'h5555_aaaa);
        chk("R10 move-to LO only", {hi_o, lo_o}, 64'h1234_5678_5555_aaaa);

        run(3'd0, 32'hFFFF_FFFE, 32'd3);
        chk("R5 signed mul overwrite", {hi_o, lo_o}, 64'hFFFF_FFFF_FFFF_FFFA);
        run(3'd1, 32'hFFFF_FFFE, 32'd3);
        chk("R6 unsigned mul", {hi_o, lo_o}, 64'h0000_0002_FFFF_FFFA);
        chk("R4 HI word", {32'd0, hi_o}, 64'd2);
        run(3'd3, 32'd2, 32'd3);
        chk("R7 carry into HI", {hi_o, lo_o}, 64'h0000_0003_0000_0000);

        mt(1, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF);
        run(3'd3, 32'd1, 32'd1);
        chk("R7 wrap to zero", {hi_o, lo_o}, 64'd0);
        run(3'd4, 32'd1, 32'd1);
        chk("R8 signed sub wrap", {hi_o, lo_o}, 64'hFFFF_FFFF_FFFF_FFFF);
        run(3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R8 unsigned sub", {hi_o, lo_o}, 64'h0000_0001_FFFF_FFFE);
        run(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R7 signed add", {hi_o, lo_o}, 64'h0000_0001_FFFF_FFFF);
        run(3'd0, 32'h8000_0000, 32'h8000_0000);
        chk("R5 most negative", {hi_o, lo_o}, 64'h4000_0000_0000_0000);

        // R9 and R11: start and move-to during busy are dropped.
        start_i = 1; op_i = 3'd1; a_i = 32'd5; b_i = 32'd5;
        @(negedge clk);
        a_i = 32'd7; b_i = 32'd7; hi_wr_i = 1; hi_wdata_i = 32'hDEAD_BEEF;
        lo_wr_i = 1; lo_wdata_i = 32'h0BAD_F00D;
        @(negedge clk);
        start_i = 0; hi_wr_i = 0; lo_wr_i = 0;
        chk("R11 write in busy dropped", {hi_o, lo_o}, 64'd25);
        @(negedge clk);
        chk("R9 no second op", {62'd0, busy_o, done_o}, 64'd0);
        chk("R9 value kept", {hi_o, lo_o}, 64'd25);

        // R2: reserved code does nothing.
        start_i = 1; op_i = 3'd6; a_i = 32'd9; b_i = 32'd9;
        @(negedge clk);
        op_i = 3'd7;
        @(negedge clk);
        start_i = 0;
        chk("R2 reserved no busy", {63'd0, busy_o}, 64'd0);
        @(negedge clk);
        chk("R2 reserved no done", {63'd0, done_o}, 64'd0);
        chk("R2 reserved hilo", {hi_o, lo_o}, 64'd25);

        // R10: write on the accepting edge lands before the accumulate.
        hi_wr_i = 1; hi_wdata_i = 32'h0000_0010; lo_wr_i = 1; lo_wdata_i = 32'hFFFF_FFFF;
        run(3'd3, 32'd1, 32'd1);
        hi_wr_i = 0; lo_wr_i = 0;
        chk("R10 write then madd", {hi_o, lo_o}, 64'h0000_0011_0000_0000);

        repeat (4) @(negedge clk);
        chk("R12 idle hold", {hi_o, lo_o}, 64'h0000_0011_0000_0000);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule